// File: doc/BRIEF.md
# Queued Command Tag and Issue Controller

This block sits on the host side of a disk link that supports command queuing. Each read or write request it takes from the host gets the lowest free tag that is below the configured queue depth. The block then emits the fields the command needs: the tag placed in the count field, the force-unit-access flag placed in the device field, and the queued read or write opcode. A 32-bit map records every tag that is in flight. Requests are held back while the device reports busy. Busy only means the device cannot take another command yet. It says nothing about whether earlier commands have finished.

Once issued, commands finish in any order. When the device announces a DMA setup for some tag, the block looks up the buffer context index that was stored for that tag at issue time and presents it. It refuses new issues until the transfer window is reported done. Because setups select context by tag every time, transfers for different commands can interleave. Completion events arrive as tag bitmaps and are ORed into a pending register. Host software reads that register and clears it in the same step. A completion for a tag that is not in flight sets a sticky error flag.

Top module: `ncq_issue_ctrl`

## Requirements
- R1: An accepted request gets the lowest-numbered tag that is not outstanding and is below `cfg_depth` (1 to 32). That tag appears on `iss_tag` and in bits 7:3 of `iss_count_fld` (bits 2:0 are zero) during the single-cycle `iss_valid` pulse in the cycle after acceptance.
- R2: A tag that is outstanding is never handed out again. `full` is high, and `req_ready` is low, whenever every tag below `cfg_depth` is outstanding.
- R3: `iss_opcode` is 8'h60 for a read (`req_write`=0) and 8'h61 for a write. In `iss_dev_fld`, bit 7 carries the FUA flag, bit 6 is 1 and bits 5:0 are 0.
- R4: `req_ready` is low while `dev_busy` is high, and a request offered in that state is not issued. When `dev_busy` is low, a request can be issued once per cycle.
- R5: A `dma_setup` strobe with `dma_tag` makes `ctx_valid` pulse in the next cycle. At that point `ctx_idx` equals the `req_ctx` value that was stored when the tag was issued. Setups for different tags may interleave in any order.
- R6: From a `dma_setup` strobe until a `dma_done` strobe, `req_ready` stays low and nothing is issued.
- R7: The bits of a completion for outstanding tags are ORed into the pending register, which `rd_data` shows. Those tags are removed from the outstanding map and can be allocated again.
- R8: A `host_rd` strobe returns the value on `rd_data` and clears the register at the clock edge. Completion bits that arrive in the same cycle as the read remain pending afterwards.
- R9: A completion bit for a tag that is not outstanding sets `proto_err`, which stays set until reset. That bit changes neither the pending register nor the outstanding map.
- R10: After reset no tag is outstanding, `rd_data` is zero, `proto_err` is low, `iss_valid` and `ctx_valid` are low, and `req_ready` follows `dev_busy` alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_depth | input | 6 | Usable queue depth, 1 to 32 |
| dev_busy | input | 1 | Device cannot accept a command |
| req_valid | input | 1 | Host offers a command request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_fua | input | 1 | Force unit access for this command |
| req_ctx | input | 8 | Buffer context index for this command |
| req_ready | output | 1 | Request accepted this cycle if valid |
| full | output | 1 | All tags below depth outstanding |
| iss_valid | output | 1 | Command fields valid (one cycle) |
| iss_tag | output | 5 | Tag of the issued command |
| iss_count_fld | output | 8 | Count field carrying the tag |
| iss_dev_fld | output | 8 | Device field carrying FUA |
| iss_opcode | output | 8 | Queued read or write opcode |
| dma_setup | input | 1 | DMA setup event strobe |
| dma_tag | input | 5 | Tag named by the setup event |
| dma_done | input | 1 | End of the current transfer window |
| ctx_valid | output | 1 | Context lookup result valid |
| ctx_idx | output | 8 | Buffer context index of the served tag |
| cpl_valid | input | 1 | Completion event strobe |
| cpl_bits | input | 32 | Completed tags, one bit per tag |
| host_rd | input | 1 | Host reads and clears pending |
| rd_data | output | 32 | Pending completion bits |
| proto_err | output | 1 | Sticky completion-of-free-tag error |

## Verification
The bench frees a tag in the middle of the map and checks that the next request takes that hole, not the next unused tag. An allocator that scans upward from its last tag, or one that ignores the depth limit, gives a different number there, or issues past `full` when the depth is reduced to three. It offers a request while a DMA setup is active and performs setups that interleave between two tags. A design that drops the window would issue mid-transfer, and one that latched the context only once would report the wrong buffer. It also makes a completion arrive in the same cycle as the host read, and sends a completion for a tag that is already free. A naive clear-on-read would lose the new bit, and a design without the membership check would set a phantom pending bit.

// File: rtl/ncq_pkg.sv
package ncq_pkg;
  localparam int NCQ_TAGS  = 32;
  localparam int NCQ_TAGW  = $clog2(NCQ_TAGS);
  localparam int NCQ_CTXW  = 8;

  typedef enum logic [7:0] {
    OPC_QRD = 8'h60,
    OPC_QWR = 8'h61
  } ncq_opc_e;

  typedef struct packed {
    logic [7:0] count_fld;
    logic [7:0] dev_fld;
    logic [7:0] opcode;
  } ncq_cmd_t;
endpackage

// File: rtl/ncq_tag_alloc.sv
module ncq_tag_alloc #(
  parameter int NTAG = ncq_pkg::NCQ_TAGS,
  localparam int TAGW = $clog2(NTAG)
) (
  input  logic [NTAG-1:0] busy_map,
  input  logic [TAGW:0]   depth,
  output logic [TAGW-1:0] tag,
  output logic            full
);
  logic [NTAG-1:0] free_map;

  always_comb begin
    for (int i = 0; i < NTAG; i++)
      free_map[i] = !busy_map[i] && ((TAGW+1)'(i) < depth);
  end

  always_comb begin
    tag = '0;
    for (int i = NTAG-1; i >= 0; i--)
      if (free_map[i]) tag = i[TAGW-1:0];
  end

  assign full = (free_map == '0);
endmodule

// File: rtl/ncq_ctx_table.sv
module ncq_ctx_table #(
  parameter int NTAG = ncq_pkg::NCQ_TAGS,
  parameter int CTXW = ncq_pkg::NCQ_CTXW,
  localparam int TAGW = $clog2(NTAG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [TAGW-1:0] wr_tag,
  input  logic [CTXW-1:0] wr_ctx,
  input  logic            rd_en,
  input  logic [TAGW-1:0] rd_tag,
  output logic            rd_valid,
  output logic [CTXW-1:0] rd_ctx
);
  logic [CTXW-1:0] ent_q [NTAG];

  for (genvar g = 0; g < NTAG; g++) begin : g_ent
    logic ld;
    assign ld = wr_en && (wr_tag == g[TAGW-1:0]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  ent_q[g] <= '0;
      else if (ld) ent_q[g] <= wr_ctx;
    end
  end

  logic [CTXW-1:0] ctx_d;
  assign ctx_d = ent_q[rd_tag];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_ctx   <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_ctx <= ctx_d;
    end
  end

  // R5
  setup_gives_ctx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
endmodule

// File: rtl/ncq_cpl_merge.sv
module ncq_cpl_merge #(
  parameter int NTAG = ncq_pkg::NCQ_TAGS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cpl_valid,
  input  logic [NTAG-1:0] cpl_bits,
  input  logic [NTAG-1:0] outst,
  input  logic            host_rd,
  output logic [NTAG-1:0] good_bits,
  output logic [NTAG-1:0] pending,
  output logic            err
);
  logic [NTAG-1:0] bad_bits, pend_d;
  logic            err_d;

  always_comb begin
    good_bits = cpl_valid ? (cpl_bits & outst)  : '0;
    bad_bits  = cpl_valid ? (cpl_bits & ~outst) : '0;
    pend_d    = (host_rd ? '0 : pending) | good_bits;
    err_d     = err | (|bad_bits);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= '0;
      err     <= 1'b0;
    end else begin
      pending <= pend_d;
      err     <= err_d;
    end
  end

  // R8
  race_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid && host_rd) |=> ((pending & $past(cpl_bits & outst)) == $past(cpl_bits & outst)));
  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
endmodule

// File: rtl/ncq_issue_ctrl.sv
module ncq_issue_ctrl
  import ncq_pkg::*;
#(
  parameter int NTAG = NCQ_TAGS,
  parameter int CTXW = NCQ_CTXW,
  localparam int TAGW = $clog2(NTAG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TAGW:0]   cfg_depth,
  input  logic            dev_busy,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic            req_fua,
  input  logic [CTXW-1:0] req_ctx,
  output logic            req_ready,
  output logic            full,
  output logic            iss_valid,
  output logic [TAGW-1:0] iss_tag,
  output logic [7:0]      iss_count_fld,
  output logic [7:0]      iss_dev_fld,
  output logic [7:0]      iss_opcode,
  input  logic            dma_setup,
  input  logic [TAGW-1:0] dma_tag,
  input  logic            dma_done,
  output logic            ctx_valid,
  output logic [CTXW-1:0] ctx_idx,
  input  logic            cpl_valid,
  input  logic [NTAG-1:0] cpl_bits,
  input  logic            host_rd,
  output logic [NTAG-1:0] rd_data,
  output logic            proto_err
);
  logic [NTAG-1:0] outst_q, outst_d, good_bits;
  logic [TAGW-1:0] alloc_tag, tag_q;
  logic            dma_q, dma_d, fire, vld_q;
  ncq_cmd_t        cmd_d, cmd_q;

  ncq_tag_alloc #(.NTAG(NTAG)) u_alloc (
    .busy_map(outst_q), .depth(cfg_depth), .tag(alloc_tag), .full(full));

  ncq_ctx_table #(.NTAG(NTAG), .CTXW(CTXW)) u_ctx (
    .clk(clk), .rst_n(rst_n), .wr_en(fire), .wr_tag(alloc_tag), .wr_ctx(req_ctx),
    .rd_en(dma_setup), .rd_tag(dma_tag), .rd_valid(ctx_valid), .rd_ctx(ctx_idx));

  ncq_cpl_merge #(.NTAG(NTAG)) u_cpl (
    .clk(clk), .rst_n(rst_n), .cpl_valid(cpl_valid), .cpl_bits(cpl_bits),
    .outst(outst_q), .host_rd(host_rd), .good_bits(good_bits),
    .pending(rd_data), .err(proto_err));

  always_comb begin
    req_ready = !dev_busy && !full && !dma_q;
    fire      = req_valid && req_ready;
    dma_d     = dma_setup ? 1'b1 : (dma_done ? 1'b0 : dma_q);
    outst_d   = outst_q & ~good_bits;
    if (fire) outst_d[alloc_tag] = 1'b1;
    cmd_d.count_fld = {alloc_tag, {(8-TAGW){1'b0}}};
    cmd_d.dev_fld   = {req_fua, 1'b1, 6'b0};
    cmd_d.opcode    = req_write ? OPC_QWR : OPC_QRD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outst_q <= '0;
      dma_q   <= 1'b0;
      vld_q   <= 1'b0;
      tag_q   <= '0;
      cmd_q   <= '0;
    end else begin
      outst_q <= outst_d;
      dma_q   <= dma_d;
      vld_q   <= fire;
      if (fire) begin
        tag_q <= alloc_tag;
        cmd_q <= cmd_d;
      end
    end
  end

  assign iss_valid     = vld_q;
  assign iss_tag       = tag_q;
  assign iss_count_fld = cmd_q.count_fld;
  assign iss_dev_fld   = cmd_q.dev_fld;
  assign iss_opcode    = cmd_q.opcode;

  // R2
  unique_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> !outst_q[alloc_tag]);
  // R2
  full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !req_ready);
  // R4
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_busy |-> !fire);
  // R6
  dma_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_q |-> !fire);
  // R1
  issue_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> outst_q[iss_tag] || $past(cpl_valid));
endmodule

// File: tb/tb_ncq_issue_ctrl.sv
`timescale 1ns/1ps
module tb_ncq_issue_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  cfg_depth;
  logic        dev_busy, req_valid, req_write, req_fua;
  logic [7:0]  req_ctx;
  logic        req_ready, full, iss_valid;
  logic [4:0]  iss_tag;
  logic [7:0]  iss_count_fld, iss_dev_fld, iss_opcode;
  logic        dma_setup, dma_done, ctx_valid;
  logic [4:0]  dma_tag;
  logic [7:0]  ctx_idx;
  logic        cpl_valid, host_rd, proto_err;
  logic [31:0] cpl_bits, rd_data;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  ncq_issue_ctrl dut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [5:0] depth);
    rst_n = 1'b0; cfg_depth = depth; dev_busy = 0; req_valid = 0; req_write = 0;
    req_fua = 0; req_ctx = 0; dma_setup = 0; dma_tag = 0; dma_done = 0;
    cpl_valid = 0; cpl_bits = 0; host_rd = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic issue(input logic wr, input logic fua, input logic [7:0] ctx,
                       input logic [4:0] exp_tag, input string req);
    req_valid = 1; req_write = wr; req_fua = fua; req_ctx = ctx;
    #0.5;
    check({req, " ready"}, req_ready, 1);
    @(posedge clk); #1 req_valid = 0;
    @(negedge clk);
    check({req, " iss_valid"}, iss_valid, 1);
    check({req, " tag"}, iss_tag, exp_tag);
    check({req, " count field"}, iss_count_fld, {exp_tag, 3'b000});
  endtask

  task automatic complete(input logic [31:0] bits);
    cpl_valid = 1; cpl_bits = bits;
    @(posedge clk); #1 cpl_valid = 0; cpl_bits = 0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    check("R10 ready", req_ready, 1);
    check("R10 pending", rd_data, 0);
    check("R10 err", proto_err, 0);
    check("R10 iss_valid", iss_valid, 0);
    check("R10 ctx_valid", ctx_valid, 0);
    check("R10 full", full, 0);
  endtask

  task automatic t_fields;
    issue(0, 0, 8'hA0, 5'd0, "R1 first");
    check("R3 read opcode", iss_opcode, 8'h60);
    check("R3 dev no fua", iss_dev_fld, 8'h40);
    issue(1, 1, 8'hA1, 5'd1, "R1 second");
    check("R3 write opcode", iss_opcode, 8'h61);
    check("R3 dev fua", iss_dev_fld, 8'hC0);
    issue(0, 0, 8'hA2, 5'd2, "R1 third");
    check("R4 single pulse", iss_valid, 1);
    @(negedge clk);
    check("R4 pulse ends", iss_valid, 0);
  endtask

  task automatic t_busy;
    dev_busy = 1; req_valid = 1;
    #0.5 check("R4 ready while busy", req_ready, 0);
    @(negedge clk);
    check("R4 no issue while busy", iss_valid, 0);
    req_valid = 0; dev_busy = 0;
    @(negedge clk);
  endtask

  task automatic t_reuse;
    complete(32'h2);
    check("R7 pending tag1", rd_data, 32'h2);
    issue(0, 0, 8'hB1, 5'd1, "R7 reuse hole");
  endtask

  task automatic t_dma;
    dma_setup = 1; dma_tag = 5'd2;
    @(posedge clk); #1 dma_setup = 0;
    @(negedge clk);
    check("R5 ctx valid", ctx_valid, 1);
    check("R5 ctx tag2", ctx_idx, 8'hA2);
    req_valid = 1;
    #0.5 check("R6 ready in window", req_ready, 0);
    @(negedge clk);
    check("R6 no issue in window", iss_valid, 0);
    req_valid = 0;
    dma_setup = 1; dma_tag = 5'd0;
    @(posedge clk); #1 dma_tag = 5'd1;
    @(negedge clk);
    check("R5 interleave tag0", ctx_idx, 8'hA0);
    @(posedge clk); #1 dma_setup = 0;
    @(negedge clk);
    check("R5 interleave tag1", ctx_idx, 8'hB1);
    check("R6 still blocked", req_ready, 0);
    dma_done = 1;
    @(posedge clk); #1 dma_done = 0;
    @(negedge clk);
    check("R6 released", req_ready, 1);
  endtask

  task automatic t_race;
    check("R8 before read", rd_data, 32'h2);
    host_rd = 1; cpl_valid = 1; cpl_bits = 32'h4;
    @(posedge clk); #1 host_rd = 0; cpl_valid = 0; cpl_bits = 0;
    @(negedge clk);
    check("R8 same-cycle bit kept", rd_data, 32'h4);
    host_rd = 1;
    @(posedge clk); #1 host_rd = 0;
    @(negedge clk);
    check("R8 cleared", rd_data, 0);
  endtask

  task automatic t_error;
    complete(32'h4);
    check("R9 err set", proto_err, 1);
    check("R9 pending untouched", rd_data, 0);
    issue(0, 0, 8'hC2, 5'd2, "R9 map unchanged then R7 tag2 free");
    repeat (3) @(negedge clk);
    check("R9 sticky", proto_err, 1);
  endtask

  task automatic t_depth;
    do_reset(6'd3);
    issue(0, 0, 8'h10, 5'd0, "R2 d0");
    issue(0, 0, 8'h11, 5'd1, "R2 d1");
    issue(0, 0, 8'h12, 5'd2, "R2 d2");
    check("R2 full", full, 1);
    req_valid = 1;
    #0.5 check("R2 ready when full", req_ready, 0);
    @(negedge clk);
    check("R2 no issue when full", iss_valid, 0);
    req_valid = 0;
    complete(32'h2);
    check("R2 not full", full, 0);
    issue(1, 0, 8'h13, 5'd1, "R2 refill");
    check("R2 full again", full, 1);
  endtask

  initial begin
    do_reset(6'd32);
    t_reset();
    t_fields();
    t_busy();
    t_reuse();
    t_dma();
    t_race();
    t_error();
    t_depth();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule